// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block delivers inter-processor interrupts among up to eight processors. A processor triggers an interrupt by writing a trigger word on a shared write bus. The bus also carries the ID of the processor that wrote it. A two-bit filter field in that word picks the targets. The block then marks the interrupt pending for each chosen target. Each pending entry remembers which processor raised it, so the same interrupt number raised by two senders is kept as two separate entries.

Each target has its own acknowledge and end-of-interrupt handshake. `ack_data` always shows what an acknowledge would return right now: the lowest eligible interrupt ID, with its sender in bits 12:10. When nothing is eligible it shows the spurious ID 1023. Pulsing `ack_req` takes the shown entry, moving it from pending to active. An active interrupt number is not offered to that target again until one of two things happens. Either the acknowledged word is written back on the end-of-interrupt port, or the interrupt's bit is written as one to that target's clear-active register.

Top module: `sgi_dispatch`

## Requirements
- R1: Trigger word bits 25:24 = 0 sends the interrupt to every processor whose bit is set in the list at bits 23:16 (bit 16 = processor 0).
- R2: Filter value 1 sends the interrupt to every processor except the requester.
- R3: Filter value 2 sends the interrupt to the requester only.
- R4: Filter value 3 is reserved; such a write sets no pending state anywhere.
- R5: The acknowledge word carries the interrupt ID in bits 9:0 and the sender ID in bits 12:10. The ID comes from trigger bits 3:0, and all other bits are zero.
- R6: With nothing eligible, the acknowledge word is 1023 with sender field 0 (also after reset). An acknowledge then changes no state.
- R7: An acknowledge moves the shown entry from pending to active. While any entry of an interrupt number is active on a target, that number is not offered to that target, even if it is triggered again.
- R8: Writing the acknowledged word to a target's end-of-interrupt port clears that active entry, so a pending copy can be acknowledged again.
- R9: Writing a mask with bit n set to a target's clear-active register clears the active state of interrupt n on that target only, for all senders.
- R10: Among eligible entries the lowest interrupt ID is offered first; within one ID the lowest sender ID is offered first.
- R11: The same interrupt number raised by different senders is held and delivered as separate entries.
- R12: Each targeted processor gets exactly one delivery per trigger; a second acknowledge returns spurious.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_we | input | 1 | Trigger word write strobe |
| trig_src | input | 3 | ID of the processor writing the trigger |
| trig_wdata | input | 32 | Trigger word: filter 25:24, list 23:16, ID 3:0 |
| ack_req | input | 8 | Per-target acknowledge pulse |
| ack_data | output | 256 | Per-target acknowledge word, 32 bits each |
| eoi_we | input | 8 | Per-target end-of-interrupt strobe |
| eoi_wdata | input | 256 | Per-target end-of-interrupt word, 32 bits each |
| clr_we | input | 1 | Clear-active write strobe |
| clr_cpu | input | 3 | Target whose active state is cleared |
| clr_wdata | input | 16 | Write-one-to-clear mask of interrupt numbers |

## Verification
The assertions assume that a requester ID on the trigger bus names an existing processor. They also assume an acknowledge pulse lasts one cycle and is only sampled while its strobe is high. The quiet-spurious property further assumes no trigger, end-of-interrupt or clear write arrives in the same cycle. The bench drives every strobe for a single cycle from the falling edge. It only uses requester IDs 0 to 7, and it keeps acknowledges apart from other writes whenever it checks that a spurious acknowledge leaves state untouched.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int ID_W     = 10;
  localparam int SRC_LSB  = 10;
  localparam int SRC_W    = 3;
  localparam int SPURIOUS = 1023;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_RSVD   = 2'd3
  } filt_e;

  // Builds an acknowledge word; the sender field reads zero for IDs of 16 or more.
  function automatic logic [31:0] pack_ack(input logic [ID_W-1:0] id,
                                           input logic [SRC_W-1:0] src);
    logic [31:0] w;
    w = 32'(id);
    if (id < 10'd16) w[SRC_LSB +: SRC_W] = src;
    return w;
  endfunction

  // Expands a filter code into a target bitmap.
  function automatic logic [7:0] filter_targets(input filt_e flt,
                                                input logic [SRC_W-1:0] src,
                                                input logic [7:0] list);
    logic [7:0] self_bit;
    self_bit = 8'b1 << src;
    case (flt)
      FLT_LIST:   return list;
      FLT_OTHERS: return ~self_bit;
      FLT_SELF:   return self_bit;
      default:    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  localparam int SGI_IW = $clog2(NUM_SGI)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [SRC_W-1:0]   src,
  input  logic [31:0]        wdata,
  output logic [NUM_CPU-1:0] tgt,
  output logic [SGI_IW-1:0]  id
);
  filt_e      flt;
  logic [7:0] full_map;

  always_comb begin
    flt      = filt_e'(wdata[25:24]);
    full_map = filter_targets(flt, src, wdata[23:16]);
    tgt      = we ? full_map[NUM_CPU-1:0] : '0;
    id       = wdata[SGI_IW-1:0];
  end

  // R4: reserved filter code reaches no target
  p_rsvd_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[25:24] == 2'd3) |-> (tgt == '0));
  // R3: self filter reaches at most one target
  p_self_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[25:24] == 2'd2) |-> ($countones(tgt) <= 1));
  // R2: the requester never receives its own broadcast
  p_others_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[25:24] == 2'd1 && int'(src) < NUM_CPU) |-> !tgt[src]);
endmodule

// File: rtl/sgi_cpu_ctrl.sv
module sgi_cpu_ctrl
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  localparam int SGI_IW = $clog2(NUM_SGI)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_vld,
  input  logic [SGI_IW-1:0] set_id,
  input  logic [SRC_W-1:0]  set_src,
  input  logic              ack_req,
  output logic [31:0]       ack_data,
  input  logic              eoi_vld,
  input  logic [31:0]       eoi_data,
  input  logic              clr_vld,
  input  logic [NUM_SGI-1:0] clr_bits
);
  logic [NUM_SGI-1:0][NUM_CPU-1:0] pend_q, act_q;
  logic [NUM_SGI-1:0] elig;
  logic               found;
  logic               ack_fire;
  logic [SGI_IW-1:0]  sel_id;
  logic [SRC_W-1:0]   sel_src;

  // eligibility and lowest-ID, lowest-sender pick
  always_comb begin
    found   = 1'b0;
    sel_id  = '0;
    sel_src = '0;
    for (int i = 0; i < NUM_SGI; i++)
      elig[i] = (|pend_q[i]) && !(|act_q[i]);
    for (int i = NUM_SGI - 1; i >= 0; i--)
      if (elig[i]) begin
        found  = 1'b1;
        sel_id = SGI_IW'(i);
      end
    for (int s = NUM_CPU - 1; s >= 0; s--)
      if (pend_q[sel_id][s]) sel_src = SRC_W'(s);
    ack_data = found ? pack_ack(ID_W'(sel_id), sel_src)
                     : pack_ack(ID_W'(SPURIOUS), '0);
    ack_fire = ack_req && found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      for (int i = 0; i < NUM_SGI; i++)
        for (int s = 0; s < NUM_CPU; s++) begin
          if (set_vld && set_id == SGI_IW'(i) && set_src == SRC_W'(s))
            pend_q[i][s] <= 1'b1;
          else if (ack_fire && sel_id == SGI_IW'(i) && sel_src == SRC_W'(s))
            pend_q[i][s] <= 1'b0;
          if (ack_fire && sel_id == SGI_IW'(i) && sel_src == SRC_W'(s))
            act_q[i][s] <= 1'b1;
          else if ((eoi_vld && eoi_data[ID_W-1:0] == ID_W'(i) &&
                    eoi_data[SRC_LSB +: SRC_W] == SRC_W'(s)) ||
                   (clr_vld && clr_bits[i]))
            act_q[i][s] <= 1'b0;
        end
    end
  end

  // R6: a spurious acknowledge alone leaves all state untouched
  p_spur_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && ack_data[ID_W-1:0] == ID_W'(SPURIOUS) && !set_vld && !eoi_vld && !clr_vld)
    |=> ($stable(pend_q) && $stable(act_q)));
  // R6: spurious word carries a zero sender field
  p_spur_sender_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_data[ID_W-1:0] == ID_W'(SPURIOUS)) |-> (ack_data[31:ID_W] == '0));
  // R7: an acknowledged entry is active in the next cycle
  p_ack_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && ack_data[ID_W-1:0] != ID_W'(SPURIOUS))
    |=> act_q[$past(sel_id)][$past(sel_src)]);
  // R12: the acknowledged pending entry is consumed unless retriggered
  p_ack_consume_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && ack_data[ID_W-1:0] != ID_W'(SPURIOUS) && !set_vld)
    |=> !pend_q[$past(sel_id)][$past(sel_src)]);
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int NUM_SGI = 16,
  localparam int SGI_IW = $clog2(NUM_SGI)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig_we,
  input  logic [2:0]              trig_src,
  input  logic [31:0]             trig_wdata,
  input  logic [NUM_CPU-1:0]      ack_req,
  output logic [NUM_CPU*32-1:0]   ack_data,
  input  logic [NUM_CPU-1:0]      eoi_we,
  input  logic [NUM_CPU*32-1:0]   eoi_wdata,
  input  logic                    clr_we,
  input  logic [2:0]              clr_cpu,
  input  logic [NUM_SGI-1:0]      clr_wdata
);
  logic [NUM_CPU-1:0] tgt;
  logic [SGI_IW-1:0]  trig_id;

  sgi_target_decode #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (trig_we),
    .src   (trig_src),
    .wdata (trig_wdata),
    .tgt   (tgt),
    .id    (trig_id)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic clr_hit;
    assign clr_hit = clr_we && (clr_cpu == 3'(c));
    sgi_cpu_ctrl #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vld  (tgt[c]),
      .set_id   (trig_id),
      .set_src  (trig_src),
      .ack_req  (ack_req[c]),
      .ack_data (ack_data[c*32 +: 32]),
      .eoi_vld  (eoi_we[c]),
      .eoi_data (eoi_wdata[c*32 +: 32]),
      .clr_vld  (clr_hit),
      .clr_bits (clr_wdata)
    );
  end
endmodule

// File: tb/tb_sgi_dispatch.sv
module tb_sgi_dispatch;
  localparam int NC = 8;
  localparam logic [31:0] SPUR = 32'd1023;

  logic clk = 0, rst_n = 0;
  logic trig_we = 0;
  logic [2:0] trig_src = 0;
  logic [31:0] trig_wdata = 0;
  logic [NC-1:0] ack_req = 0, eoi_we = 0;
  logic [NC*32-1:0] ack_data, eoi_wdata = '0;
  logic clr_we = 0;
  logic [2:0] clr_cpu = 0;
  logic [15:0] clr_wdata = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sgi_dispatch dut (.*);

  function automatic logic [31:0] exp_word(int id, int src);
    return (32'(src) << 10) | 32'(id);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] view(int c);
    return ack_data[c*32 +: 32];
  endfunction

  task automatic trig(int src, int flt, int lst, int id);
    trig_src = 3'(src);
    trig_wdata = (32'(flt) << 24) | (32'(lst) << 16) | 32'(id);
    trig_we = 1;
    @(negedge clk);
    trig_we = 0;
  endtask

  task automatic ack(int c, output logic [31:0] v);
    v = view(c);
    ack_req[c] = 1;
    @(negedge clk);
    ack_req[c] = 0;
  endtask

  task automatic eoi(int c, logic [31:0] w);
    eoi_wdata[c*32 +: 32] = w;
    eoi_we[c] = 1;
    @(negedge clk);
    eoi_we[c] = 0;
  endtask

  task automatic clr(int c, logic [15:0] m);
    clr_cpu = 3'(c); clr_wdata = m; clr_we = 1;
    @(negedge clk);
    clr_we = 0;
  endtask

  task automatic ack_expect(int c, logic [31:0] e, string tag);
    logic [31:0] v;
    ack(c, v);
    chk(v == e, tag, v, e);
    if (v != SPUR) eoi(c, v);
  endtask

  task automatic t_reset();
    for (int c = 0; c < NC; c++) chk(view(c) == SPUR, "R6 reset idle", view(c), SPUR);
  endtask

  task automatic t_self();
    logic [31:0] v;
    trig(1, 2, 0, 1);
    for (int c = 0; c < NC; c++)
      chk(view(c) == (c == 1 ? exp_word(1, 1) : SPUR), "R3 self target", view(c), c == 1 ? exp_word(1, 1) : SPUR);
    ack(1, v);
    chk(v == 32'h401, "R5 ack word format", v, 32'h401);
    chk(view(1) == SPUR, "R12 single delivery", view(1), SPUR);
    eoi(1, v);
  endtask

  task automatic t_others();
    trig(1, 1, 0, 1);
    chk(view(1) == SPUR, "R2 requester excluded", view(1), SPUR);
    for (int c = 0; c < NC; c++)
      if (c != 1) begin
        ack_expect(c, exp_word(1, 1), "R2 others delivered");
        chk(view(c) == SPUR, "R12 one per target", view(c), SPUR);
      end
  endtask

  task automatic t_list();
    trig(5, 0, 8'h24, 3);
    for (int c = 0; c < NC; c++)
      chk(view(c) == ((c == 2 || c == 5) ? exp_word(3, 5) : SPUR), "R1 list targets",
          view(c), (c == 2 || c == 5) ? exp_word(3, 5) : SPUR);
    ack_expect(2, exp_word(3, 5), "R1 list ack");
    ack_expect(5, exp_word(3, 5), "R1 list ack");
  endtask

  task automatic t_rsvd();
    trig(0, 3, 8'hff, 4);
    for (int c = 0; c < NC; c++) chk(view(c) == SPUR, "R4 reserved ignored", view(c), SPUR);
  endtask

  task automatic t_spur();
    logic [31:0] v;
    ack(0, v);
    chk(v == SPUR, "R6 spurious ack", v, SPUR);
    chk(view(0) == SPUR, "R6 no state change", view(0), SPUR);
    trig(3, 0, 8'h01, 2);
    ack_expect(0, exp_word(2, 3), "R5 sender field");
  endtask

  task automatic t_prio();
    logic [31:0] v;
    trig(6, 0, 8'h10, 5);
    trig(2, 0, 8'h10, 5);
    trig(0, 0, 8'h10, 9);
    ack(4, v);
    chk(v == exp_word(5, 2), "R10 lowest id and sender", v, exp_word(5, 2));
    ack_expect(4, exp_word(9, 0), "R7 active id skipped");
    chk(view(4) == SPUR, "R7 blocked while active", view(4), SPUR);
    eoi(4, v);
    ack_expect(4, exp_word(5, 6), "R11 second sender kept");
  endtask

  task automatic t_eoi();
    logic [31:0] v;
    trig(0, 0, 8'h08, 1);
    ack(3, v);
    chk(v == exp_word(1, 0), "R7 first ack", v, exp_word(1, 0));
    trig(0, 0, 8'h08, 1);
    chk(view(3) == SPUR, "R7 retrigger held", view(3), SPUR);
    eoi(3, v);
    ack_expect(3, exp_word(1, 0), "R8 eoi re-enables");
  endtask

  task automatic t_clr();
    logic [31:0] v;
    trig(7, 0, 8'h40, 1);
    ack(6, v);
    chk(v == exp_word(1, 7), "R9 first ack", v, exp_word(1, 7));
    trig(7, 0, 8'h40, 1);
    clr(7, 16'h0002);
    chk(view(6) == SPUR, "R9 other target untouched", view(6), SPUR);
    clr(6, 16'h0001);
    chk(view(6) == SPUR, "R9 other bit untouched", view(6), SPUR);
    clr(6, 16'h0002);
    chk(view(6) == exp_word(1, 7), "R9 clear-active re-enables", view(6), exp_word(1, 7));
    ack(6, v);
    clr(6, 16'h0002);
    chk(view(6) == SPUR, "R12 nothing left", view(6), SPUR);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_self();
    t_others();
    t_list();
    t_rsvd();
    t_spur();
    t_prio();
    t_eoi();
    t_clr();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule